// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Byte Lanes

This block is a single-port synchronous static RAM built for late-write timing. On each rising clock edge it registers the address, the select, the write strobe and one write strobe per byte lane. A write's data does not arrive with its command. It is sampled on the edge after the command, and a small pending-write register holds the address and lane mask until then. Reads come out of a registered output stage. This gives edge-to-edge timing, with a read visible after the edge that follows its command.

Each lane holds nine bits: eight data bits and one extra bit. The lane count is a parameter. Two lanes give an 18-bit word and four lanes give a 36-bit word. When a read targets the word that still waits for its late data, it is served by merging that data into the array word. An asynchronous active-low output enable gates the data drive flag. An active-high sleep input blocks new commands.

Top module: `late_write_sram`

## Requirements
- R1: After synchronous reset the data drive flag `q_drv` is low and no write is pending.
- R2: A write command is `cs_n`=0, `we_n`=0, `sleep`=0 at an edge. Its address is taken at that edge and its data from `d_in` at the next edge. The stored word can then be read back.
- R3: A write changes only the lanes whose `be_n` bit is 0. With all `be_n` bits at 1 it changes nothing.
- R4: During a read command (`cs_n`=0, `we_n`=1, `sleep`=0) the value of `be_n` has no effect on the returned word.
- R5: Read data for a command registered at edge N appears on `q` with `q_drv` high after edge N+1, as long as `oe_n` is low.
- R6: A read issued on the edge that takes the late data of a write to the same address returns the new data in that write's enabled lanes and the old data in the other lanes.
- R7: Writes may be issued on consecutive edges. Each edge's `d_in` completes the previous write while the new write's address and mask are captured.
- R8: With `cs_n`=1 at an edge, no read or write is started, and `q_drv` is low after the following edge.
- R9: `oe_n`=1 forces `q_drv` low at once, without a clock edge. Returning `oe_n` to 0 restores the drive flag of the last read.
- R10: While `sleep`=1 at an edge, no command is accepted there. A write accepted on the edge before still takes its late data.
- R11: Lane k occupies bits [9k+8:9k] of `d_in` and `q` and is enabled by `be_n[k]`. `LANES` selects 2 (18-bit) or 4 (36-bit) words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| be_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| d_in | input | 9*LANES | Late write data, sampled one edge after its command |
| sleep | input | 1 | Blocks new commands, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| q | output | 9*LANES | Registered read data, zero when not driven |
| q_drv | output | 1 | High while `q` is being driven |

## Verification
A read registered at edge N is due after edge N+1. So the bench keeps a two-deep queue of expected words and compares the queue's tail at the falling edge that follows each later edge. In the same slot, every cycle with no read due is checked for a released drive flag. A write's data is handed on by the bench to the next cycle's stimulus. The reference model commits it at that edge, before it evaluates any read at the same edge, and this is how the forwarding case is predicted. The output-enable check changes `oe_n` between edges and samples one time unit later, with no clock edge in between.

// File: rtl/lw_pkg.sv
package lw_pkg;
  localparam int LANE_BITS = 9;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } lw_op_e;
endpackage

// File: rtl/lw_cmd_stage.sv
module lw_cmd_stage
  import lw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  be_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sleep,
  output logic              rd_go,
  output logic              pend_valid,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [LANES-1:0]  pend_mask
);
  lw_op_e op_now;

  always_comb begin
    if (sleep || cs_n)
      op_now = OP_IDLE;
    else if (we_n)
      op_now = OP_READ;
    else
      op_now = OP_WRITE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_go      <= 1'b0;
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_mask  <= '0;
    end else begin
      rd_go      <= (op_now == OP_READ);
      pend_valid <= (op_now == OP_WRITE);
      if (op_now == OP_WRITE) begin
        pend_addr <= addr;
        pend_mask <= ~be_n;
      end
    end
  end
endmodule

// File: rtl/lw_lane_ram.sv
module lw_lane_ram #(
  parameter int ADDR_W = 6,
  parameter int WIDTH  = 9
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)
      cells[wr_addr] <= wr_data;
    rd_data <= cells[rd_addr];
  end
endmodule

// File: rtl/lw_read_path.sv
module lw_read_path
  import lw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pend_valid,
  input  logic [ADDR_W-1:0]          pend_addr,
  input  logic [LANES-1:0]           pend_mask,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [LANES*LANE_BITS-1:0] d_in,
  input  logic                       rd_go,
  input  logic [LANES*LANE_BITS-1:0] arr_word,
  input  logic                       oe_n,
  output logic [LANES*LANE_BITS-1:0] q,
  output logic                       q_drv
);
  localparam int DW = LANES * LANE_BITS;

  logic [LANES-1:0] fwd_mask;
  logic [DW-1:0]    fwd_data;
  logic [DW-1:0]    merged;
  logic [DW-1:0]    q_reg;
  logic             drv_reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_mask <= '0;
      fwd_data <= '0;
    end else begin
      fwd_mask <= (pend_valid && (pend_addr == addr)) ? pend_mask : '0;
      fwd_data <= d_in;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_merge
    assign merged[k*LANE_BITS +: LANE_BITS] = fwd_mask[k]
      ? fwd_data[k*LANE_BITS +: LANE_BITS]
      : arr_word[k*LANE_BITS +: LANE_BITS];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_reg   <= '0;
      drv_reg <= 1'b0;
    end else begin
      drv_reg <= rd_go;
      if (rd_go)
        q_reg <= merged;
    end
  end

  assign q_drv = drv_reg & ~oe_n;
  assign q     = q_drv ? q_reg : '0;
endmodule

// File: rtl/late_write_sram.sv
module late_write_sram
  import lw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs_n,
  input  logic                       we_n,
  input  logic [LANES-1:0]           be_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [LANES*LANE_BITS-1:0] d_in,
  input  logic                       sleep,
  input  logic                       oe_n,
  output logic [LANES*LANE_BITS-1:0] q,
  output logic                       q_drv
);
  localparam int DW = LANES * LANE_BITS;

  logic              rd_go;
  logic              pend_valid;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_mask;
  logic [DW-1:0]     arr_word;

  lw_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .we_n       (we_n),
    .be_n       (be_n),
    .addr       (addr),
    .sleep      (sleep),
    .rd_go      (rd_go),
    .pend_valid (pend_valid),
    .pend_addr  (pend_addr),
    .pend_mask  (pend_mask)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lw_lane_ram #(.ADDR_W(ADDR_W), .WIDTH(LANE_BITS)) u_ram (
      .clk     (clk),
      .wr_en   (pend_valid & pend_mask[k]),
      .wr_addr (pend_addr),
      .wr_data (d_in[k*LANE_BITS +: LANE_BITS]),
      .rd_addr (addr),
      .rd_data (arr_word[k*LANE_BITS +: LANE_BITS])
    );
  end

  lw_read_path #(.ADDR_W(ADDR_W), .LANES(LANES)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .pend_valid (pend_valid),
    .pend_addr  (pend_addr),
    .pend_mask  (pend_mask),
    .addr       (addr),
    .d_in       (d_in),
    .rd_go      (rd_go),
    .arr_word   (arr_word),
    .oe_n       (oe_n),
    .q          (q),
    .q_drv      (q_drv)
  );
endmodule

// File: rtl/lw_checker.sv
module lw_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             we_n,
  input logic             sleep,
  input logic             oe_n,
  input logic [LANES-1:0] be_n,
  input logic             q_drv,
  input logic             rd_go,
  input logic             pend_valid,
  input logic [LANES-1:0] pend_mask
);
  // R10
  sleep_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (!pend_valid && !rd_go));

  // R2
  write_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !we_n && !sleep) |=> pend_valid);

  // R3
  mask_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !we_n && !sleep) |=> (pend_mask == ~$past(be_n)));

  // R8
  deselect_release_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> ##1 !q_drv);

  // R5
  read_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && we_n && !sleep) |=> ##1 (oe_n || q_drv));

  // R9
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !q_drv);
endmodule

bind late_write_sram lw_checker #(.LANES(LANES)) u_chk (.*);

// File: tb/tb_late_write_sram.sv
module tb_late_write_sram;
  localparam int AW = 4;
  localparam int LN = 2;
  localparam int DW = LN * 9;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1, we_n = 1'b1, sleep = 1'b0, oe_n = 1'b0;
  logic [LN-1:0] be_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] q;
  logic          q_drv;

  late_write_sram #(.ADDR_W(AW), .LANES(LN)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .be_n(be_n),
    .addr(addr), .d_in(d_in), .sleep(sleep), .oe_n(oe_n),
    .q(q), .q_drv(q_drv)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] mmem [NW];
  logic          m_pv = 1'b0;
  logic [AW-1:0] m_pa = '0;
  logic [LN-1:0] m_pm = '0;
  logic [DW-1:0] carry = '0;
  logic          e1_v = 1'b0, e2_v = 1'b0;
  logic [DW-1:0] e1_q = '0, e2_q = '0;
  string         e1_tag = "R1", e2_tag = "R1";

  task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a * 4111 + salt * 997 + 77) % (1 << DW));
  endfunction

  // One clock cycle: check the due result, drive a command, then update the model.
  task automatic step(input logic c, input logic w, input logic [LN-1:0] be,
                      input int a, input logic [DW-1:0] wd, input logic s, input string tag);
    @(negedge clk);
    if (e2_v)
      chk(q_drv === 1'b1 && q === e2_q, e2_tag, q, e2_q);
    else
      chk(q_drv === 1'b0, e2_tag, {{(DW-1){1'b0}}, q_drv}, '0);
    cs_n = c; we_n = w; be_n = be; addr = AW'(a); d_in = carry; sleep = s;
    @(posedge clk);
    e2_v = e1_v; e2_q = e1_q; e2_tag = e1_tag;
    // R11: lane k is bits [9k+8:9k]
    if (m_pv)
      for (int k = 0; k < LN; k++)
        if (m_pm[k]) mmem[m_pa][k*9 +: 9] = d_in[k*9 +: 9];
    e1_tag = tag;
    e1_v = (!c && w && !s);
    if (e1_v) e1_q = mmem[AW'(a)];
    m_pv = (!c && !w && !s);
    if (m_pv) begin
      m_pa = AW'(a); m_pm = ~be; carry = wd;
    end
  endtask

  task automatic wr(input int a, input logic [LN-1:0] be, input logic [DW-1:0] wd, input string tag);
    step(1'b0, 1'b0, be, a, wd, 1'b0, tag);
  endtask
  task automatic rd(input int a, input logic [LN-1:0] be, input string tag);
    step(1'b0, 1'b1, be, a, '0, 1'b0, tag);
  endtask
  task automatic idle(input string tag);
    step(1'b1, 1'b1, '1, 0, '0, 1'b0, tag);
  endtask

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) mmem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1
    chk(q_drv === 1'b0, "R1", {{(DW-1){1'b0}}, q_drv}, '0);

    // R2 R7: back-to-back full writes over every address
    for (int a = 0; a < NW; a++) wr(a, 2'b00, pat(a, 1), "R7");
    idle("R2");
    // R5: read every address
    for (int a = 0; a < NW; a++) rd(a, 2'b00, "R5");
    idle("R5"); idle("R5");

    // R3 R11: single-lane and no-lane writes
    for (int a = 0; a < NW; a++)
      wr(a, (a % 3 == 0) ? 2'b10 : (a % 3 == 1) ? 2'b01 : 2'b11, pat(a, 2), "R3");
    idle("R3");
    for (int a = 0; a < NW; a++) rd(a, 2'b00, "R3");
    idle("R3"); idle("R3");

    // R4: byte enables on reads have no effect
    for (int a = 0; a < NW; a++) rd(a, LN'(a), "R4");
    idle("R4"); idle("R4");

    // R6: read on the late-data edge of a write to the same address
    for (int a = 0; a < NW; a++) begin
      wr(a, LN'(a + 1), pat(a, 3), "R6");
      rd(a, 2'b00, "R6");
      rd((a + 5) % NW, 2'b00, "R6");
    end
    idle("R6"); idle("R6");

    // R8: deselect cycles with write strobe low change nothing
    for (int a = 0; a < NW; a++) begin
      rd(a, 2'b00, "R8");
      step(1'b1, 1'b0, 2'b00, a, pat(a, 9), 1'b0, "R8");
      step(1'b1, 1'b1, 2'b00, a, '0, 1'b0, "R8");
    end
    for (int a = 0; a < NW; a++) rd(a, 2'b00, "R8");
    idle("R8"); idle("R8");

    // R10: writes and reads under sleep are dropped; an accepted write completes
    step(1'b0, 1'b0, 2'b00, 3, pat(3, 20), 1'b1, "R10");
    step(1'b0, 1'b1, 2'b00, 3, '0, 1'b1, "R10");
    wr(4, 2'b00, pat(4, 21), "R10");
    step(1'b0, 1'b1, 2'b00, 4, '0, 1'b1, "R10");
    idle("R10");
    rd(3, 2'b00, "R10"); rd(4, 2'b00, "R10");
    idle("R10"); idle("R10");

    // R9: output enable acts between edges
    rd(7, 2'b00, "R9");
    idle("R9");
    #2;
    chk(q_drv === 1'b1, "R9", {{(DW-1){1'b0}}, q_drv}, 1);
    #2 oe_n = 1'b1;
    #1 chk(q_drv === 1'b0 && q === '0, "R9", q, '0);
    #1 oe_n = 1'b0;
    #1 chk(q_drv === 1'b1 && q === mmem[7], "R9", q, mmem[7]);
    idle("R9"); idle("R9");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule